// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog whose timeout runs in two back-to-back phases, both counted in ticks of a free-running prescaler. Software turns the timer on, then restarts the first phase with a kick to show that it is still alive. If no kick arrives before the first phase runs out, the block raises a pretimeout interrupt and moves on to the second phase. The second phase is a grace period that software cannot stop with a kick. Only clearing the enable stops it. When the grace period ends, the block raises the final interrupt and, in that same cycle, sends a one-cycle request on one of three reset lines.

The three reset lines are a whole-chip reset, a reset of only the CPU and crypto engine, and a software-only restart. The reset-mode field in the control register picks which line is used. Software reaches the block through a small synchronous register port with three 32-bit words: a kick/status word, a control word and an interrupt mask. Each phase is set from 1 to 32 ticks. One tick lasts 2^(PRE_BASE + 2·sel) clock cycles, where sel is a 2-bit prescale select.

Top module: `wdt2_top`

## Requirements
- R1: After reset, every output is low and the three registers read back as zero: the timer is disabled, the mask is clear, the flags are clear, and reset mode 0 (CPU reset) is selected.
- R2: Writing control offset 0x4 with bit 31 set, while the timer is disabled, starts phase 1. Status flag bit 0 (pretimeout) is then set exactly N1·T cycles after the write, where T = 2^(PRE_BASE+2·sel) and N1 is the phase 1 length.
- R3: Phase 2 begins only when phase 1 expires. The reset request comes exactly N2·T cycles after phase 1 expires.
- R4: Control bits 26:22 hold the phase 1 length minus one, and bits 19:15 hold the phase 2 length minus one, so each phase lasts 1 to 32 ticks.
- R5: Writing 1 to bit 31 of offset 0x0 in phase 1 kicks the timer. The kick restarts both the phase 1 count and the prescaler, so the pretimeout comes N1·T cycles after the kick.
- R6: A kick in phase 2 is ignored, and the reset request still comes at its original cycle.
- R7: Writing the control register with bit 31 clear stops the timer and returns it to idle. No reset request follows. A later enable starts a fresh phase 1.
- R8: Control bits 1:0 select the reset line: 0 or 3 selects the CPU reset, 1 selects the chip reset, and 2 selects the software reset. At most one reset line is ever high.
- R9: A reset request lasts exactly one cycle. In that same cycle the enable bit is cleared, and the block stays idle afterwards.
- R10: Status flag bit 1 (final) is set in the same cycle as the reset request.
- R11: Status bits 1:0 are cleared by writing 1 to them at offset 0x0. Mask bit 0 at offset 0x8 lets flag bit 0 drive irq_pre, and mask bit 1 lets flag bit 1 drive irq_final.
- R12: Control bits 9:8 select the prescale. Each step up makes the tick four times longer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address; bits 3:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pre | output | 1 | Pretimeout interrupt (flag 0 AND mask 0) |
| irq_final | output | 1 | Final interrupt (flag 1 AND mask 1) |
| rst_req_chip | output | 1 | Whole-chip reset request pulse |
| rst_req_cpu | output | 1 | CPU and crypto-engine reset request pulse |
| rst_req_soft | output | 1 | Software restart request pulse |

## Verification
The assertions check the following on every cycle:
- at most one reset line is high, and each request lasts one cycle;
- the enable drops together with a request;
- phase 2 is only ever entered from phase 1;
- a kick clears the count in phase 1 and leaves it untouched in phase 2;
- the prescaler returns to zero after a tick or a clear.

The exact cycle counts of both phases for several lengths and prescale settings can only be shown by the bench scenarios. The same holds for the line chosen by each mode code, a disable in the middle of phase 2, and the interaction between the mask and write-1-to-clear.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ONE  = 2'd1,
        PH_TWO  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        RM_CPU   = 2'd0,
        RM_CHIP  = 2'd1,
        RM_SOFT  = 2'd2,
        RM_CPU_B = 2'd3
    } rmode_e;

    localparam int LEN_W  = 5;
    localparam int PSEL_W = 2;

    typedef struct packed {
        logic              en;
        logic [LEN_W-1:0]  len1m;
        logic [LEN_W-1:0]  len2m;
        logic [PSEL_W-1:0] psel;
        logic [1:0]        mode;
    } ctrl_t;

    localparam logic [1:0] WORD_KICK = 2'd0;
    localparam logic [1:0] WORD_CTRL = 2'd1;
    localparam logic [1:0] WORD_MASK = 2'd2;

endpackage

// File: rtl/wdt2_presc.sv
module wdt2_presc #(
    parameter int PRE_BASE = 22,
    parameter int PRE_STEP = 2,
    parameter int PSEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int MAX_SHIFT = PRE_BASE + PRE_STEP * ((1 << PSEL_W) - 1);
    localparam int PW        = MAX_SHIFT + 1;

    typedef struct packed {
        logic [PW-1:0] cnt;
    } presc_t;

    presc_t        q, d;
    logic [PW-1:0] limit;
    logic [PW-1:0] one;

    always_comb begin
        one   = {{(PW-1){1'b0}}, 1'b1};
        limit = (one << (PRE_BASE + PRE_STEP * int'(psel))) - one;
        tick  = run && !clr && (q.cnt >= limit);
        d     = q;
        if (clr) begin
            d.cnt = '0;
        end else if (run) begin
            d.cnt = tick ? '0 : q.cnt + one;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_tick_wraps_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (q.cnt == '0));

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0));

endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [3:0]  addr,
    input  logic [31:0] wdata,
    input  logic [1:0]  set_flags,
    input  logic        clr_en,
    output logic [31:0] rdata,
    output ctrl_t       ctrl,
    output logic        start,
    output logic        stop,
    output logic        kick,
    output logic        irq_pre,
    output logic        irq_final
);
    typedef struct packed {
        ctrl_t      ctrl;
        logic [1:0] mask;
        logic [1:0] flags;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d     = q;
        start = 1'b0;
        stop  = 1'b0;
        kick  = 1'b0;
        if (wr) begin
            case (addr[3:2])
                WORD_KICK: begin
                    kick    = wdata[31];
                    d.flags = q.flags & ~wdata[1:0];
                end
                WORD_CTRL: begin
                    d.ctrl.en    = wdata[31];
                    d.ctrl.len1m = wdata[26:22];
                    d.ctrl.len2m = wdata[19:15];
                    d.ctrl.psel  = wdata[9:8];
                    d.ctrl.mode  = wdata[1:0];
                    start        = wdata[31] && !q.ctrl.en;
                    stop         = !wdata[31];
                end
                WORD_MASK: d.mask = wdata[1:0];
                default: ;
            endcase
        end
        d.flags = d.flags | set_flags;
        if (clr_en) d.ctrl.en = 1'b0;
    end

    always_comb begin
        case (addr[3:2])
            WORD_KICK: rdata = {30'd0, q.flags};
            WORD_CTRL: rdata = {q.ctrl.en, 4'd0, q.ctrl.len1m, 2'd0, q.ctrl.len2m,
                                5'd0, q.ctrl.psel, 6'd0, q.ctrl.mode};
            WORD_MASK: rdata = {30'd0, q.mask};
            default:   rdata = 32'd0;
        endcase
    end

    assign ctrl      = q.ctrl;
    assign irq_pre   = q.flags[0] & q.mask[0];
    assign irq_final = q.flags[1] & q.mask[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_flag_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags[0] |=> q.flags[0]);

    assert_final_latches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags[1] |=> q.flags[1]);

endmodule

// File: rtl/wdt2_phase.sv
module wdt2_phase
    import wdt2_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctrl_t      ctrl,
    input  logic       start,
    input  logic       stop,
    input  logic       kick,
    input  logic       tick,
    output logic       pre_clr,
    output logic       run,
    output logic [1:0] set_flags,
    output logic       clr_en,
    output logic       rst_chip,
    output logic       rst_cpu,
    output logic       rst_soft
);
    typedef struct packed {
        phase_e           ph;
        logic [LEN_W-1:0] cnt;
        logic [2:0]       rst;
    } fsm_t;

    fsm_t q, d;
    logic kick_ok;

    always_comb begin
        d         = q;
        d.rst     = 3'b000;
        set_flags = 2'b00;
        clr_en    = 1'b0;
        kick_ok   = 1'b0;
        if (start) begin
            d.ph  = PH_ONE;
            d.cnt = '0;
        end else if (stop || !ctrl.en) begin
            d.ph  = PH_IDLE;
            d.cnt = '0;
        end else begin
            case (q.ph)
                PH_ONE: begin
                    if (kick) begin
                        kick_ok = 1'b1;
                        d.cnt   = '0;
                    end else if (tick) begin
                        if (q.cnt >= ctrl.len1m) begin
                            d.ph         = PH_TWO;
                            d.cnt        = '0;
                            set_flags[0] = 1'b1;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                PH_TWO: begin
                    if (tick) begin
                        if (q.cnt >= ctrl.len2m) begin
                            d.ph         = PH_IDLE;
                            d.cnt        = '0;
                            set_flags[1] = 1'b1;
                            clr_en       = 1'b1;
                            case (rmode_e'(ctrl.mode))
                                RM_CHIP: d.rst = 3'b001;
                                RM_SOFT: d.rst = 3'b100;
                                default: d.rst = 3'b010;
                            endcase
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                end
                default: d.cnt = '0;
            endcase
        end
    end

    assign pre_clr  = start || stop || kick_ok || (q.ph == PH_IDLE);
    assign run      = (q.ph != PH_IDLE);
    assign rst_chip = q.rst[0];
    assign rst_cpu  = q.rst[1];
    assign rst_soft = q.rst[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ph: PH_IDLE, cnt: '0, rst: 3'b000};
        else        q <= d;
    end

    assert_one_reset_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_chip, rst_cpu, rst_soft}));

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_chip || rst_cpu || rst_soft) |=> !(rst_chip || rst_cpu || rst_soft));

    assert_phase2_after_phase1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TWO && $past(q.ph) != PH_TWO) |-> $past(q.ph) == PH_ONE);

    assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_ONE && kick && ctrl.en && !stop) |=> (q.cnt == '0 && q.ph == PH_ONE));

    assert_kick_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TWO && kick && !tick && ctrl.en && !stop) |=>
            (q.ph == PH_TWO && q.cnt == $past(q.cnt)));

endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
    import wdt2_pkg::*;
#(
    parameter int PRE_BASE = 22,
    parameter int PRE_STEP = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_pre,
    output logic        irq_final,
    output logic        rst_req_chip,
    output logic        rst_req_cpu,
    output logic        rst_req_soft
);
    ctrl_t      ctrl;
    logic       start, stop, kick, tick, pre_clr, run, clr_en;
    logic [1:0] set_flags;

    wdt2_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .set_flags (set_flags),
        .clr_en    (clr_en),
        .rdata     (reg_rdata),
        .ctrl      (ctrl),
        .start     (start),
        .stop      (stop),
        .kick      (kick),
        .irq_pre   (irq_pre),
        .irq_final (irq_final)
    );

    wdt2_presc #(
        .PRE_BASE (PRE_BASE),
        .PRE_STEP (PRE_STEP),
        .PSEL_W   (PSEL_W)
    ) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .run   (run),
        .psel  (ctrl.psel),
        .tick  (tick)
    );

    wdt2_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .start     (start),
        .stop      (stop),
        .kick      (kick),
        .tick      (tick),
        .pre_clr   (pre_clr),
        .run       (run),
        .set_flags (set_flags),
        .clr_en    (clr_en),
        .rst_chip  (rst_req_chip),
        .rst_cpu   (rst_req_cpu),
        .rst_soft  (rst_req_soft)
    );

    assert_enable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_chip || rst_req_cpu || rst_req_soft) |-> !ctrl.en);

    assert_no_run_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !start) |=> !(rst_req_chip || rst_req_cpu || rst_req_soft));

endmodule

// File: tb/sim_wdt2_top.sv
module sim_wdt2_top;

    localparam int BASE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        irq_pre, irq_final, rst_req_chip, rst_req_cpu, rst_req_soft;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    wdt2_top #(.PRE_BASE(BASE), .PRE_STEP(2)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq_pre      (irq_pre),
        .irq_final    (irq_final),
        .rst_req_chip (rst_req_chip),
        .rst_req_cpu  (rst_req_cpu),
        .rst_req_soft (rst_req_soft)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<60000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int tper(input int sel);
        return 1 << (BASE + 2 * sel);
    endfunction

    function automatic logic [31:0] cw(input bit en, input int l1, input int l2,
                                       input int sel, input int mode);
        logic [31:0] w;
        w = 32'd0;
        w[31]    = en;
        w[26:22] = 5'(l1 - 1);
        w[19:15] = 5'(l2 - 1);
        w[9:8]   = 2'(sel);
        w[1:0]   = 2'(mode);
        return w;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // which: 0 irq_pre, 1 any reset line
    task automatic wait_ev(input int which, input int maxc, output int k);
        k = -1;
        for (int i = 1; i <= maxc; i++) begin
            @(posedge clk); #1;
            if ((which == 0 && irq_pre) ||
                (which == 1 && (rst_req_chip || rst_req_cpu || rst_req_soft))) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check({irq_pre, irq_final, rst_req_chip, rst_req_cpu, rst_req_soft} == 5'd0,
              "R1 outputs", int'({irq_pre, irq_final, rst_req_chip, rst_req_cpu, rst_req_soft}), 0);
        rd(4'h0, v); check(v == 32'd0, "R1 status", int'(v), 0);
        rd(4'h4, v); check(v == 32'd0, "R1 ctrl (cpu mode)", int'(v), 0);
        rd(4'h8, v); check(v == 32'd0, "R1 mask", int'(v), 0);
    endtask

    task automatic t_basic;
        int k;
        wr(4'h8, 32'd3);
        wr(4'h4, cw(1, 2, 3, 0, 0));
        wait_ev(0, 200, k);
        check(k == 2 * tper(0), "R2 phase1 length", k, 2 * tper(0));
        wait_ev(1, 200, k);
        check(k == 3 * tper(0), "R3 phase2 length", k, 3 * tper(0));
        check(rst_req_cpu == 1'b1, "R8 default cpu line", int'(rst_req_cpu), 1);
        check(irq_final == 1'b1, "R10 final irq with reset", int'(irq_final), 1);
        wr(4'h0, 32'd3);
    endtask

    task automatic t_long;
        int k;
        wr(4'h4, cw(1, 32, 32, 0, 0));
        wait_ev(0, 400, k);
        check(k == 32 * tper(0), "R4 phase1 len 32", k, 32 * tper(0));
        wait_ev(1, 400, k);
        check(k == 32 * tper(0), "R4 phase2 len 32", k, 32 * tper(0));
        wr(4'h0, 32'd3);
    endtask

    task automatic t_kick1;
        int k;
        bit early;
        early = 1'b0;
        wr(4'h4, cw(1, 2, 1, 0, 0));
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            if (irq_pre) early = 1'b1;
        end
        wr(4'h0, 32'h8000_0000);
        check(!early, "R5 no early pretimeout", int'(early), 0);
        wait_ev(0, 200, k);
        check(k == 2 * tper(0), "R5 restart after kick", k, 2 * tper(0));
        wait_ev(1, 200, k);
        wr(4'h0, 32'd3);
    endtask

    task automatic t_kick2;
        int k;
        wr(4'h4, cw(1, 2, 3, 0, 0));
        wait_ev(0, 200, k);
        wr(4'h0, 32'h8000_0000);
        wait_ev(1, 200, k);
        check(k == 3 * tper(0) - 1, "R6 kick in phase2 ignored", k, 3 * tper(0) - 1);
        wr(4'h0, 32'd3);
    endtask

    task automatic t_disable;
        int k;
        logic [31:0] v;
        wr(4'h4, cw(1, 2, 3, 0, 0));
        wait_ev(0, 200, k);
        wr(4'h4, cw(0, 2, 3, 0, 0));
        wait_ev(1, 60, k);
        check(k == -1, "R7 no reset after disable", k, -1);
        rd(4'h4, v); check(v[31] == 1'b0, "R7 enable clear", int'(v[31]), 0);
        wr(4'h0, 32'd3);
        wr(4'h4, cw(1, 2, 3, 0, 0));
        wait_ev(0, 200, k);
        check(k == 2 * tper(0), "R7 fresh phase1 after re-enable", k, 2 * tper(0));
        wr(4'h4, cw(0, 2, 3, 0, 0));
        wr(4'h0, 32'd3);
    endtask

    task automatic t_modes;
        int k;
        logic [2:0] exp_l;
        logic [31:0] v;
        for (int m = 0; m < 4; m++) begin
            exp_l = (m == 1) ? 3'b001 : (m == 2) ? 3'b100 : 3'b010;
            wr(4'h4, cw(1, 1, 1, 0, m));
            wait_ev(1, 100, k);
            check(k == 2 * tper(0), "R3 short phases", k, 2 * tper(0));
            check({rst_req_soft, rst_req_cpu, rst_req_chip} == exp_l, "R8 mode line",
                  int'({rst_req_soft, rst_req_cpu, rst_req_chip}), int'(exp_l));
            check(irq_final == 1'b1, "R10 final irq same cycle", int'(irq_final), 1);
            @(posedge clk); #1;
            check({rst_req_soft, rst_req_cpu, rst_req_chip} == 3'b000, "R9 one-cycle pulse",
                  int'({rst_req_soft, rst_req_cpu, rst_req_chip}), 0);
            rd(4'h4, v); check(v[31] == 1'b0, "R9 enable cleared", int'(v[31]), 0);
            wait_ev(1, 30, k);
            check(k == -1, "R9 stays idle", k, -1);
            wr(4'h0, 32'd3);
        end
    endtask

    task automatic t_irq;
        int k;
        logic [31:0] v;
        wr(4'h8, 32'd0);
        wr(4'h4, cw(1, 1, 1, 0, 1));
        wait_ev(1, 100, k);
        check({irq_pre, irq_final} == 2'b00, "R11 masked lines low", int'({irq_pre, irq_final}), 0);
        rd(4'h0, v); check(v[1:0] == 2'b11, "R11 both flags set", int'(v[1:0]), 3);
        wr(4'h8, 32'd1);
        check({irq_final, irq_pre} == 2'b01, "R11 mask bit0 only", int'({irq_final, irq_pre}), 1);
        wr(4'h0, 32'd1);
        check(irq_pre == 1'b0, "R11 w1c bit0", int'(irq_pre), 0);
        rd(4'h0, v); check(v[1:0] == 2'b10, "R11 flag1 kept", int'(v[1:0]), 2);
        wr(4'h8, 32'd3);
        check(irq_final == 1'b1, "R11 mask bit1", int'(irq_final), 1);
        wr(4'h0, 32'd2);
        check(irq_final == 1'b0, "R11 w1c bit1", int'(irq_final), 0);
    endtask

    task automatic t_presc;
        int k;
        wr(4'h4, cw(1, 2, 32, 1, 0));
        wait_ev(0, 400, k);
        check(k == 2 * tper(1), "R12 sel1 tick", k, 2 * tper(1));
        wr(4'h4, cw(0, 2, 32, 1, 0));
        wr(4'h0, 32'd3);
        wr(4'h4, cw(1, 1, 32, 2, 0));
        wait_ev(0, 400, k);
        check(k == tper(2), "R12 sel2 tick", k, tper(2));
        wr(4'h4, cw(0, 1, 32, 2, 0));
        wr(4'h0, 32'd3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_long();
        t_kick1();
        t_kick2();
        t_disable();
        t_modes();
        t_irq();
        t_presc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule